// File: doc/BRIEF.md
# Boot Register Window

This block claims a 64 KiB address window at 0x1F800000 and answers the register reads that boot firmware issues before real memory-controller or companion-processor logic exists. Most offsets behave as plain read/write storage, so firmware that saves, modifies and restores configuration words sees its own values come back. A handful of offsets have fixed meaning. Two return constant words that tell the polling firmware the hardware is ready. One adjacent pair forms a small interrupt controller with a write-one-to-clear pending register and a plain mask register.

A diagnostic force input can hold pending bits set, so a bench or bring-up harness can present an interrupt source to firmware without modelling the device behind it. The block drives a single interrupt line that is high whenever an enabled bit is pending. The bus is a simple 32-bit register port: byte address, read strobe, write strobe and write data. Read data is combinational in the strobe cycle.

Top module: `boot_mmio_window`

## Requirements
- R1: Only addresses 0x1F800000 to 0x1F80FFFF are claimed. A write outside the window changes nothing, and a read outside it returns 0.
- R2: Every in-window offset without a fixed meaning stores the written word and returns it on later reads. Address bits [1:0] are ignored. Storage holds STORE_WORDS words indexed by address bits [log2(STORE_WORDS)+1:2], so word offsets alias modulo STORE_WORDS.
- R3: After reset, every storage word, the pending register and the mask register read 0, and the interrupt line is low.
- R4: A read of offset 0x1814 always returns 0xFFFFFFFF. A write there is dropped and reaches no storage word.
- R5: A read of offset 0x10F0 always returns 0x07654321. A write there, including writing back the value that was read, is dropped and reaches no storage word.
- R6: Offset 0x1070 is the pending register in bits [IRQ_BITS-1:0], and its upper bits read 0. A write clears each pending bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R7: Offset 0x1074 is the mask register. A write stores write-data bits [IRQ_BITS-1:0] directly, and the upper bits read 0.
- R8: A force-input bit that is high at a clock edge leaves the matching pending bit set after that edge. This holds even when the same edge carries a clear of that bit. After the force input drops, the bit stays pending until it is cleared.
- R9: The interrupt output is high exactly when some bit is both pending and unmasked. It follows the registered pending and mask values with no further delay.
- R10: Read data reflects the state before any write on the same edge, and reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 32 | Byte address of the access |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| diag_force_i | input | IRQ_BITS | Force-pending diagnostic sources, 0 when unused |
| irq_o | output | 1 | OR of pending AND mask |

## Verification
The bench builds the block with STORE_WORDS = 16 and IRQ_BITS = 16. With 16 storage words, every slot can be written and read back, and the aliasing of higher word offsets onto them can be checked. The same small store lets the bench check that writes to the constant offsets, and writes outside the window, leave the slots they would alias to untouched. Sixteen pending bits keep a per-bit sweep of force, mask, wrong-bit clear, right-bit clear and clear-under-force short. The bench also sweeps interrupt-output combinations arithmetically.

// File: rtl/boot_mmio_pkg.sv
package boot_mmio_pkg;

    // Kind of register an in-window offset selects
    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_STORE,
        SLOT_READY,
        SLOT_PCR,
        SLOT_STAT,
        SLOT_MASK
    } slot_kind_e;

    localparam int WIN_BITS = 16;

    localparam logic [WIN_BITS-1:0] OFS_READY = 16'h1814;
    localparam logic [WIN_BITS-1:0] OFS_PCR   = 16'h10F0;
    localparam logic [WIN_BITS-1:0] OFS_STAT  = 16'h1070;
    localparam logic [WIN_BITS-1:0] OFS_MASK  = 16'h1074;

    localparam logic [31:0] READY_WORD = 32'hFFFF_FFFF;
    localparam logic [31:0] PCR_WORD   = 32'h0765_4321;

endpackage

// File: rtl/boot_mmio_decode.sv
module boot_mmio_decode
    import boot_mmio_pkg::*;
#(
    parameter logic [31:0] WIN_BASE    = 32'h1F80_0000,
    parameter int          STORE_WORDS = 256
) (
    input  logic [31:0]                      addr_i,
    output slot_kind_e                       kind_o,
    output logic [$clog2(STORE_WORDS)-1:0]   idx_o
);
    localparam int IDX_W = $clog2(STORE_WORDS);

    logic                hit;
    logic [WIN_BITS-1:0] ofs;
    logic                unused_lsb;

    assign unused_lsb = ^addr_i[1:0];
    assign hit        = (addr_i[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
    assign ofs        = {addr_i[WIN_BITS-1:2], 2'b00};
    assign idx_o      = addr_i[IDX_W+1:2];

    always_comb begin
        if (!hit) begin
            kind_o = SLOT_NONE;
        end else begin
            unique case (ofs)
                OFS_READY: kind_o = SLOT_READY;
                OFS_PCR:   kind_o = SLOT_PCR;
                OFS_STAT:  kind_o = SLOT_STAT;
                OFS_MASK:  kind_o = SLOT_MASK;
                default:   kind_o = SLOT_STORE;
            endcase
        end
    end
endmodule

// File: rtl/boot_mmio_store.sv
module boot_mmio_store #(
    parameter int STORE_WORDS = 256
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_i,
    input  logic [$clog2(STORE_WORDS)-1:0]   idx_i,
    input  logic [31:0]                      wdata_i,
    output logic [31:0]                      rdata_o
);
    localparam int IDX_W = $clog2(STORE_WORDS);

    logic [31:0] mem_d [STORE_WORDS];
    logic [31:0] mem_q [STORE_WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr_i) begin
            mem_d[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[idx_i];

    // R2: a stored word reads back at the same index on the next cycle
    p_store_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mem_q[$past(idx_i)] == $past(wdata_i)));

    // R2: a cycle without a write leaves the addressed word unchanged
    p_store_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> (mem_q[$past(idx_i)] == $past(rdata_o)));

    logic [IDX_W-1:0] unused_idx_w;
    assign unused_idx_w = '0;
endmodule

// File: rtl/boot_mmio_irq.sv
module boot_mmio_irq #(
    parameter int IRQ_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_en_i,
    input  logic                mask_en_i,
    input  logic [IRQ_BITS-1:0] wbits_i,
    input  logic [IRQ_BITS-1:0] force_i,
    output logic [IRQ_BITS-1:0] stat_o,
    output logic [IRQ_BITS-1:0] mask_o,
    output logic                irq_o
);
    typedef struct packed {
        logic [IRQ_BITS-1:0] stat;
        logic [IRQ_BITS-1:0] mask;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en_i) begin
            st_d.stat = st_q.stat & ~wbits_i;
        end
        // Forced sources win over a clear on the same edge
        st_d.stat = st_d.stat | force_i;
        if (mask_en_i) begin
            st_d.mask = wbits_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.stat & st_q.mask);

    // R8: every forced bit is pending after the edge
    p_force_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|force_i) |=> ((stat_o & $past(force_i)) == $past(force_i)));

    // R6: cleared bits drop unless forced
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((stat_o & $past(wbits_i) & ~$past(force_i)) == '0));

    // R6: without force, a pending bit only appears through a force
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i == '0) |=> ((stat_o & ~$past(stat_o)) == '0));

    // R7: mask takes written bits
    p_mask_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_en_i |=> (mask_o == $past(wbits_i)));

    // R7: mask is stable unless written
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_en_i |=> $stable(mask_o));
endmodule

// File: rtl/boot_mmio_window.sv
module boot_mmio_window
    import boot_mmio_pkg::*;
#(
    parameter logic [31:0] WIN_BASE    = 32'h1F80_0000,
    parameter int          STORE_WORDS = 256,
    parameter int          IRQ_BITS    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         bus_addr_i,
    input  logic                bus_rd_i,
    input  logic                bus_wr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    input  logic [IRQ_BITS-1:0] diag_force_i,
    output logic                irq_o
);
    localparam int IDX_W = $clog2(STORE_WORDS);

    slot_kind_e          kind;
    logic [IDX_W-1:0]    idx;
    logic [31:0]         store_rdata;
    logic [IRQ_BITS-1:0] stat;
    logic [IRQ_BITS-1:0] mask;
    logic [31:0]         rd_word;

    boot_mmio_decode #(
        .WIN_BASE    (WIN_BASE),
        .STORE_WORDS (STORE_WORDS)
    ) u_decode (
        .addr_i (bus_addr_i),
        .kind_o (kind),
        .idx_o  (idx)
    );

    boot_mmio_store #(
        .STORE_WORDS (STORE_WORDS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i && (kind == SLOT_STORE)),
        .idx_i   (idx),
        .wdata_i (bus_wdata_i),
        .rdata_o (store_rdata)
    );

    boot_mmio_irq #(
        .IRQ_BITS (IRQ_BITS)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en_i  (bus_wr_i && (kind == SLOT_STAT)),
        .mask_en_i (bus_wr_i && (kind == SLOT_MASK)),
        .wbits_i   (bus_wdata_i[IRQ_BITS-1:0]),
        .force_i   (diag_force_i),
        .stat_o    (stat),
        .mask_o    (mask),
        .irq_o     (irq_o)
    );

    always_comb begin
        rd_word = '0;
        unique case (kind)
            SLOT_STORE: rd_word = store_rdata;
            SLOT_READY: rd_word = READY_WORD;
            SLOT_PCR:   rd_word = PCR_WORD;
            SLOT_STAT:  rd_word[IRQ_BITS-1:0] = stat;
            SLOT_MASK:  rd_word[IRQ_BITS-1:0] = mask;
            default:    rd_word = '0;
        endcase
    end

    assign bus_rdata_o = bus_rd_i ? rd_word : '0;

    // R1: reads outside the window return zero
    p_outside_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && kind == SLOT_NONE) |-> (bus_rdata_o == '0));

    // R4: ready offset always answers all ones
    p_ready_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && kind == SLOT_READY) |-> (bus_rdata_o == 32'hFFFF_FFFF));

    // R5: fixed offset survives any write
    p_pcr_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && kind == SLOT_PCR) |-> (bus_rdata_o == 32'h0765_4321));

    // R9: interrupt line implies an enabled pending bit
    p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((mask != '0) && (stat != '0)));
endmodule

// File: tb/boot_mmio_window_tb.sv
module boot_mmio_window_tb;
    localparam int SW = 16;
    localparam int IB = 16;
    localparam logic [31:0] BASE = 32'h1F80_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [IB-1:0] force_src = '0;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] model [SW];

    always #2.5 clk = ~clk;

    boot_mmio_window #(
        .WIN_BASE    (BASE),
        .STORE_WORDS (SW),
        .IRQ_BITS    (IB)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr_i   (addr),
        .bus_rd_i     (rd),
        .bus_wr_i     (wr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .diag_force_i (force_src),
        .irq_o        (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        rd = 1'b0;
    endtask

    task automatic irq_now(output logic v);
        @(negedge clk);
        #1 v = irq;
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'hA5C3_0000 ^ (32'(k) * 32'h0101_0111);
    endfunction

    task automatic check_store(input string req);
        logic [31:0] v;
        for (int k = 0; k < SW; k++) begin
            bus_read(BASE + 32'(k) * 4, v);
            chk(req, v, model[k]);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        b;

        for (int k = 0; k < SW; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: clean state after reset
        check_store("R3 store");
        bus_read(BASE + 32'h1070, v); chk("R3 stat", v, 0);
        bus_read(BASE + 32'h1074, v); chk("R3 mask", v, 0);
        irq_now(b); chk("R3 irq", 32'(b), 0);

        // R2: every slot, then aliasing and ignored low address bits
        for (int k = 0; k < SW; k++) begin
            bus_write(BASE + 32'(k) * 4, pat(k));
            model[k] = pat(k);
        end
        check_store("R2 slot");
        for (int k = 0; k < SW; k++) begin
            bus_write(BASE + 32'(k + SW) * 4 + 32'(k % 4), ~pat(k));
            model[k] = ~pat(k);
        end
        check_store("R2 alias");
        for (int k = 0; k < SW; k++) begin
            bus_read(BASE + 32'(k + 2 * SW) * 4 + 32'h3, v);
            chk("R2 alias read", v, model[k]);
        end

        // R10: read in a write cycle sees old value and read does not alter
        @(negedge clk);
        addr = BASE + 32'h8; wdata = 32'h1234_5678; wr = 1'b1; rd = 1'b1;
        #1 chk("R10 old value", rdata, model[2]);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        model[2] = 32'h1234_5678;
        bus_read(BASE + 32'h8, v); chk("R10 new value", v, model[2]);

        // R4: ready constant, write dropped (word 0x605 aliases slot 5)
        bus_read(BASE + 32'h1814, v); chk("R4 read", v, 32'hFFFF_FFFF);
        bus_write(BASE + 32'h1814, 32'h0);
        bus_read(BASE + 32'h1814, v); chk("R4 after write", v, 32'hFFFF_FFFF);
        bus_read(BASE + 32'h14, v); chk("R4 slot untouched", v, model[5]);

        // R5: fixed word, save/modify/restore leaves it (word 0x43C aliases slot 12)
        bus_read(BASE + 32'h10F0, v); chk("R5 read", v, 32'h0765_4321);
        bus_write(BASE + 32'h10F0, v | 32'h8000_0000);
        bus_read(BASE + 32'h10F0, v); chk("R5 after modify", v, 32'h0765_4321);
        bus_write(BASE + 32'h10F0, v);
        bus_read(BASE + 32'h10F0, v); chk("R5 after restore", v, 32'h0765_4321);
        bus_read(BASE + 32'h30, v); chk("R5 slot untouched", v, model[12]);

        // R1: outside the window
        for (int k = 0; k < SW; k++) begin
            bus_write(BASE + 32'h1_0000 + 32'(k) * 4, 32'hDEAD_0000 + 32'(k));
            bus_write(BASE - 32'h1_0000 + 32'(k) * 4, 32'hBEEF_0000 + 32'(k));
        end
        check_store("R1 slots untouched");
        bus_read(BASE + 32'h1_0000, v); chk("R1 above", v, 0);
        bus_read(BASE - 32'h4, v); chk("R1 below", v, 0);
        bus_read(32'h0000_1814, v); chk("R1 far", v, 0);
        bus_write(32'h1F81_1074, 32'hFFFF);
        bus_read(BASE + 32'h1074, v); chk("R1 mask untouched", v, 0);

        // R7: plain mask store, upper bits read zero
        bus_write(BASE + 32'h1074, 32'hFFFF_ABCD);
        bus_read(BASE + 32'h1074, v); chk("R7 mask", v, 32'h0000_ABCD);
        bus_write(BASE + 32'h1074, 32'h0);
        bus_read(BASE + 32'h1074, v); chk("R7 mask zero", v, 0);

        // R6 R8 R9: per-bit sweep
        for (int i = 0; i < IB; i++) begin
            logic [31:0] bit_w;
            bit_w = 32'h1 << i;
            @(negedge clk); force_src = bit_w[IB-1:0];
            @(negedge clk); force_src = '0;
            bus_read(BASE + 32'h1070, v); chk("R8 set", v, bit_w);
            irq_now(b); chk("R9 masked off", 32'(b), 0);
            bus_write(BASE + 32'h1074, bit_w);
            irq_now(b); chk("R9 enabled", 32'(b), 1);
            bus_write(BASE + 32'h1074, ~bit_w & 32'hFFFF);
            irq_now(b); chk("R9 other bits", 32'(b), 0);
            bus_write(BASE + 32'h1070, ~bit_w);
            bus_read(BASE + 32'h1070, v); chk("R6 zero keeps", v, bit_w);
            bus_write(BASE + 32'h1070, bit_w);
            bus_read(BASE + 32'h1070, v); chk("R6 one clears", v, 0);
            bus_write(BASE + 32'h1074, 32'h0);
        end

        // R8: forced bit survives a clear on the same edge
        @(negedge clk); force_src = 16'h0008;
        bus_write(BASE + 32'h1070, 32'hFFFF_FFFF);
        bus_read(BASE + 32'h1070, v); chk("R8 force beats clear", v, 32'h0008);
        @(negedge clk); force_src = '0;
        bus_read(BASE + 32'h1070, v); chk("R8 held after release", v, 32'h0008);
        bus_write(BASE + 32'h1070, 32'h0008);
        bus_read(BASE + 32'h1070, v); chk("R6 cleared after release", v, 0);

        // R9: combination sweep, pending 0x0F0F against shifted masks
        @(negedge clk); force_src = 16'h0F0F;
        @(negedge clk); force_src = '0;
        for (int s = 0; s < IB; s++) begin
            logic [15:0] m;
            m = 16'h0007 << s;
            bus_write(BASE + 32'h1074, 32'(m));
            irq_now(b);
            chk("R9 combo", 32'(b), 32'(|(m & 16'h0F0F)));
        end
        bus_write(BASE + 32'h1070, 32'hFFFF);
        irq_now(b); chk("R9 all cleared", 32'(b), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule